// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the protocol core of a two-wire (I2C) serial memory device. A fast system clock samples the bus clock and data lines through a synchronizer. The block detects bus framing events and walks through the command sequence: a device-select byte, a word-address byte, then either incoming write bytes or outgoing read bytes. It acknowledges the master by enabling an open-drain pull-down on the data line.

Toward the storage side it presents a read address with byte-wide read data, and a single-cycle write strobe with its own address and data. The storage is expected to return read data within a couple of system clocks. Three select bits in the device byte are split by the memory-size parameter. The low ones supply high memory-address bits. The rest must match three strap inputs. A write-protect input blocks every store.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A falling data line while the clock is high is a START; a rising data line while the clock is high is a STOP. A START in the middle of a command (repeated START) restarts the device-select phase.
- R2: Before a START all bus activity is ignored (no acknowledge, no drive). A STOP ends any command in progress, so a partly received data byte is never stored.
- R3: The device byte is sent most significant bit first. Its top four bits must be 1010 and its last bit selects the direction (1 read, 0 write); any other prefix gets no acknowledge.
- R4: Of device-byte bits 3:1, the lowest ADDR_W-8 carry memory-address bits 8 and up (bit 1 to address bit 8). Each remaining bit k+1 must equal strap input pin_sel[k]. A mismatch gets no acknowledge, and later bytes are ignored until the next START.
- R5: The data line is pulled low during the ninth clock after a matching device byte, after the word-address byte and after every write byte. Each complete write byte gives exactly one single-cycle store strobe.
- R6: A read byte is driven most significant bit first and the line is released on the ninth clock. Another byte follows only if the master pulls the line low on that clock; after a release (no acknowledge) the block stops driving until a new START.
- R7: Each byte read advances the address by one across the whole space, wrapping from the top address to zero. A read without a word-address byte continues from the current address.
- R8: Successive write bytes advance only the low PAGE_W address bits, wrapping within a page of 2^PAGE_W bytes.
- R9: Bus data is taken on rising clock edges. The pull-down changes only while the clock is low, so an output bit is stable for the whole high phase.
- R10: While wp is high no store strobe is issued, but write bytes are still acknowledged and the address still advances.
- R11: After reset the data line is released and no store strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least eight times the bus clock rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | 1 enables the open-drain pull-down on the data line |
| pin_sel | input | 3 | Strap inputs compared with device-byte select bits |
| wp | input | 1 | Write protect, high blocks all stores |
| mem_rd_addr | output | ADDR_W | Current byte address toward storage |
| mem_rd_data | input | 8 | Byte stored at mem_rd_addr |
| mem_wr_en | output | 1 | Single-cycle store strobe |
| mem_wr_addr | output | ADDR_W | Address of the byte being stored |
| mem_wr_data | output | 8 | Byte being stored |

## Verification
The bench builds the block with ADDR_W = 9 and PAGE_W = 2, backed by a 512-byte model. This leaves one select bit as memory-address bit 8 and two bits matched against the straps, so all eight select-field values can be swept against one strap setting, along with all fifteen wrong prefixes. Pages of four bytes make in-page wrap appear after a few writes, and the small space puts the top-to-zero read wrap at address 0x1FF within easy reach.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  localparam int BYTE_BITS = 8;
  localparam logic [3:0] DEV_PREFIX = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WORD,
    ST_WR,
    ST_RDARM,
    ST_RD
  } ee_state_t;
endpackage

// File: rtl/i2c_ee_bus_front.sv
module i2c_ee_bus_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [SYNC_STAGES:0] scl_p;
  logic [SYNC_STAGES:0] sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[SYNC_STAGES-1:0], scl_in};
      sda_p <= {sda_p[SYNC_STAGES-1:0], sda_in};
    end
  end

  logic scl_now, scl_old, sda_now, sda_old;
  assign scl_now = scl_p[SYNC_STAGES-1];
  assign scl_old = scl_p[SYNC_STAGES];
  assign sda_now = sda_p[SYNC_STAGES-1];
  assign sda_old = sda_p[SYNC_STAGES];

  assign scl_lvl   = scl_now;
  assign sda_lvl   = sda_now;
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign bus_start = scl_now & scl_old & sda_old & ~sda_now;
  assign bus_stop  = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/i2c_ee_dev_match.sv
module i2c_ee_dev_match
  import i2c_ee_pkg::*;
#(
  parameter int EXT_BITS = 3
) (
  input  logic [7:0] dev_byte,
  input  logic [2:0] pins,
  output logic       hit
);
  logic [2:0] field_ok;

  for (genvar k = 0; k < 3; k++) begin : g_sel
    if (k < EXT_BITS) begin : g_mem_bit
      assign field_ok[k] = 1'b1;
    end else begin : g_pin_bit
      assign field_ok[k] = (dev_byte[k+1] == pins[k]);
    end
  end

  assign hit = (dev_byte[7:4] == DEV_PREFIX) && (&field_ok);
endmodule

// File: rtl/i2c_ee_ctrl.sv
module i2c_ee_ctrl
  import i2c_ee_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              sda_bit,
  input  logic              dev_hit,
  input  logic              wp,
  input  logic [7:0]        rd_data,
  output logic [7:0]        rx_byte,
  output logic              sda_pull,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  localparam int EXT_BITS = ADDR_W - 8;
  localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'((1 << PAGE_W) - 1);
  localparam logic [3:0] ACK_SLOT = 4'd8;
  localparam logic [3:0] END_SLOT = 4'd9;

  ee_state_t         state;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg;
  logic [7:0]        tx;
  logic [ADDR_W-1:0] addr;
  logic              mst_ack_n;

  logic [ADDR_W-1:0] addr_dev;
  logic [ADDR_W-1:0] addr_word;
  logic [ADDR_W-1:0] addr_page_next;

  always_comb begin
    addr_dev = addr;
    for (int i = 0; i < EXT_BITS; i++) addr_dev[8+i] = shreg[1+i];
    addr_word = addr;
    addr_word[7:0] = shreg;
    addr_page_next = (addr & ~PAGE_MASK) | ((addr + ADDR_W'(1)) & PAGE_MASK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      tx        <= '0;
      addr      <= '0;
      mst_ack_n <= 1'b1;
      sda_pull  <= 1'b0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (bus_stop) begin
        state    <= ST_IDLE;
        bitcnt   <= '0;
        sda_pull <= 1'b0;
      end else if (bus_start) begin
        state    <= ST_DEV;
        bitcnt   <= '0;
        sda_pull <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (scl_rise) begin
          if (bitcnt < ACK_SLOT) shreg <= {shreg[6:0], sda_bit};
          else mst_ack_n <= sda_bit;
          if (bitcnt < END_SLOT) bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall) begin
          if (bitcnt == ACK_SLOT) begin
            unique case (state)
              ST_DEV: begin
                if (dev_hit) begin
                  sda_pull <= 1'b1;
                  addr     <= addr_dev;
                  state    <= shreg[0] ? ST_RDARM : ST_WORD;
                end else begin
                  state <= ST_IDLE;
                end
              end
              ST_WORD: begin
                sda_pull <= 1'b1;
                addr     <= addr_word;
                state    <= ST_WR;
              end
              ST_WR: begin
                sda_pull <= 1'b1;
                wr_en    <= ~wp;
                wr_addr  <= addr;
                wr_data  <= shreg;
                addr     <= addr_page_next;
              end
              default: sda_pull <= 1'b0;
            endcase
          end else if (bitcnt == END_SLOT) begin
            bitcnt   <= '0;
            sda_pull <= 1'b0;
            if (state == ST_RDARM || (state == ST_RD && !mst_ack_n)) begin
              tx       <= {rd_data[6:0], 1'b0};
              sda_pull <= ~rd_data[7];
              addr     <= addr + ADDR_W'(1);
              state    <= ST_RD;
            end else if (state == ST_RD) begin
              state <= ST_IDLE;
            end
          end else if (state == ST_RD && bitcnt != 4'd0) begin
            sda_pull <= ~tx[7];
            tx       <= {tx[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign rx_byte = shreg;
  assign rd_addr = addr;

  // R2: an idle engine never drives the line
  p_idle_released_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_pull);

  // R10: a store strobe only follows a cycle with protection off
  p_store_unprotected_r10: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !$past(wp));

  // R5: one strobe per byte, never two cycles in a row
  p_store_single_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R9: the pull-down moves only while the bus clock is low
  p_pull_moves_low_r9: assert property (@(posedge clk) disable iff (rst)
    (sda_pull != $past(sda_pull)) |-> !scl_lvl);

  // R5: outside reading, the line is only pulled in the acknowledge slot
  p_ack_slot_only_r5: assert property (@(posedge clk) disable iff (rst)
    (sda_pull && state != ST_RD) |-> (bitcnt >= ACK_SLOT));
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2c_ee_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull,
  input  logic [2:0]        pin_sel,
  input  logic              wp,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [7:0]        mem_wr_data
);
  localparam int EXT_BITS = ADDR_W - 8;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
  logic [7:0] rx_byte;
  logic dev_hit;

  i2c_ee_bus_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .bus_start(bus_start),
    .bus_stop (bus_stop)
  );

  i2c_ee_dev_match #(.EXT_BITS(EXT_BITS)) u_match (
    .dev_byte(rx_byte),
    .pins    (pin_sel),
    .hit     (dev_hit)
  );

  i2c_ee_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .scl_lvl  (scl_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .bus_start(bus_start),
    .bus_stop (bus_stop),
    .sda_bit  (sda_lvl),
    .dev_hit  (dev_hit),
    .wp       (wp),
    .rd_data  (mem_rd_data),
    .rx_byte  (rx_byte),
    .sda_pull (sda_pull),
    .rd_addr  (mem_rd_addr),
    .wr_en    (mem_wr_en),
    .wr_addr  (mem_wr_addr),
    .wr_data  (mem_wr_data)
  );
endmodule

// File: tb/i2c_eeprom_slave_test.sv
module i2c_eeprom_slave_test;
  localparam int AW = 9;
  localparam int PW = 2;
  localparam int MEMSZ = 1 << AW;
  localparam int H = 10;
  localparam int LIMIT = 190000;
  localparam logic [2:0] PINS = 3'b101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_pull;
  logic sda_line;
  logic [AW-1:0] mem_rd_addr;
  logic [7:0] mem_rd_data;
  logic mem_wr_en;
  logic [AW-1:0] mem_wr_addr;
  logic [7:0] mem_wr_data;

  logic [7:0] mem [MEMSZ];
  logic [7:0] expm [MEMSZ];
  int total = 0;
  int fails = 0;
  int cyc = 0;
  int wr_pulses = 0;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  i2c_eeprom_slave #(.ADDR_W(AW), .PAGE_W(PW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line), .sda_pull(sda_pull),
    .pin_sel(PINS), .wp(wp), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  function automatic logic [7:0] init_val(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MEMSZ; i++) mem[i] <= init_val(i);
    end else if (mem_wr_en) begin
      mem[mem_wr_addr] <= mem_wr_data;
    end
    mem_rd_data <= mem[mem_rd_addr];
    if (!rst && mem_wr_en) wr_pulses++;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == LIMIT) begin
      total++;
      fails++;
      $display("FAIL watchdog (all requirements): got %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] devb(input int a, input bit rd);
    return {4'b1010, PINS[2:1], 1'(a >> 8), rd};
  endfunction

  task automatic bus_start();
    wait_clk(H); sda_m = 1'b1; wait_clk(H); scl = 1'b1; wait_clk(H);
    sda_m = 1'b0; wait_clk(H); scl = 1'b0; wait_clk(2);
  endtask

  task automatic bus_stop();
    wait_clk(2); sda_m = 1'b0; wait_clk(H); scl = 1'b1; wait_clk(H);
    sda_m = 1'b1; wait_clk(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wait_clk(H); scl = 1'b1; wait_clk(H); scl = 1'b0; wait_clk(2);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; wait_clk(H); scl = 1'b1; wait_clk(H / 2);
    ack = ~sda_line;
    wait_clk(H / 2); scl = 1'b0; wait_clk(2);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b, output bit stable);
    logic v1, v2;
    stable = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_clk(H); scl = 1'b1; wait_clk(2); v1 = sda_line;
      wait_clk(H - 4); v2 = sda_line;
      if (v1 != v2) stable = 1'b0;
      b[i] = v1;
      wait_clk(2); scl = 1'b0; wait_clk(2);
    end
    sda_m = mack ? 1'b0 : 1'b1;
    wait_clk(H); scl = 1'b1; wait_clk(H); scl = 1'b0; wait_clk(2);
    sda_m = 1'b1;
  endtask

  // write n bytes from address a; data = seed + 17*k
  task automatic do_write(input int a, input int n, input int seed, input bit store);
    bit ack;
    int pa;
    bus_start();
    send_byte(devb(a, 1'b0), ack); chk("R5 device ack (write)", ack, 1);
    send_byte(8'(a), ack);         chk("R5 word address ack", ack, 1);
    pa = a;
    for (int k = 0; k < n; k++) begin
      send_byte(8'(seed + 17 * k), ack);
      chk(wp ? "R10 data ack under protect" : "R5 data ack", ack, 1);
      if (store) expm[pa] = 8'(seed + 17 * k);
      pa = (pa & ~((1 << PW) - 1)) | ((pa + 1) & ((1 << PW) - 1));  // R8 in-page wrap
    end
    bus_stop();
  endtask

  // read n bytes; random=1 sets the address with a dummy write and repeated START
  task automatic do_read(input int a, input int n, input bit random);
    bit ack, stable;
    logic [7:0] b;
    int pa;
    bus_start();
    if (random) begin
      send_byte(devb(a, 1'b0), ack); chk("R3 device ack (dummy write)", ack, 1);
      send_byte(8'(a), ack);         chk("R5 word address ack", ack, 1);
      bus_start();  // R1 repeated START
    end
    send_byte(devb(a, 1'b1), ack); chk("R1 R3 device ack (read)", ack, 1);
    pa = a;
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b, stable);
      chk("R6 R7 read data", b, expm[pa]);
      chk("R9 bit stable while clock high", stable, 1);
      pa = (pa + 1) % MEMSZ;
    end
    bus_stop();
  endtask

  initial begin
    bit ack, ack2, stable;
    logic [7:0] b;
    int w0;
    for (int i = 0; i < MEMSZ; i++) expm[i] = init_val(i);
    wait_clk(5);
    chk("R11 line released in reset", sda_pull, 0);
    rst = 1'b0;
    wait_clk(5);
    chk("R11 line released after reset", sda_pull, 0);
    chk("R11 no store strobe after reset", mem_wr_en, 0);

    // R2: a matching byte without START is ignored
    send_byte(devb(0, 1'b0), ack);
    chk("R2 no ack before START", ack, 0);
    bus_stop();

    // R4: sweep the three-bit select field
    for (int f = 0; f < 8; f++) begin
      bus_start();
      send_byte({4'b1010, 3'(f), 1'b0}, ack);
      chk("R4 select field ack", ack, (3'(f) >> 1) == PINS[2:1] ? 1 : 0);
      send_byte(8'h00, ack2);
      chk("R4 next byte follows match", ack2, (3'(f) >> 1) == PINS[2:1] ? 1 : 0);
      bus_stop();
    end

    // R3: every wrong prefix is refused
    for (int p = 0; p < 16; p++) begin
      if (p != 10) begin
        bus_start();
        send_byte({4'(p), PINS[2:1], 1'b0, 1'b0}, ack);
        chk("R3 wrong prefix refused", ack, 0);
        bus_stop();
      end
    end

    // R5: single byte write, one strobe
    w0 = wr_pulses;
    do_write(9'h135, 1, 8'hC3, 1'b1);
    chk("R5 one strobe per byte", wr_pulses - w0, 1);
    do_read(9'h135, 1, 1'b1);

    // R8: six bytes into a four-byte page starting at offset 2
    w0 = wr_pulses;
    do_write(9'h0A6, 6, 8'h40, 1'b1);
    chk("R8 strobe count for page write", wr_pulses - w0, 6);

    // R6 R7: sequential read over the page and beyond
    do_read(9'h0A4, 8, 1'b1);
    // after the release, nothing is driven (R6)
    bus_start();
    send_byte(devb(9'h0AC, 1'b1), ack);
    chk("R6 device ack (read)", ack, 1);
    recv_byte(1'b0, b, stable);
    chk("R7 current-address read continues", b, expm[9'h0AC]);
    recv_byte(1'b0, b, stable);
    chk("R6 no drive after master release", b, 8'hFF);
    bus_stop();

    // R7: wrap from the top address to zero
    do_read(9'h1FE, 4, 1'b1);

    // R10: protected write, no strobes, address still moves
    wp = 1'b1;
    w0 = wr_pulses;
    do_write(9'h050, 3, 8'h99, 1'b0);
    chk("R10 no strobes while protected", wr_pulses - w0, 0);
    wp = 1'b0;
    do_read(9'h053, 1, 1'b0);
    do_read(9'h050, 3, 1'b1);

    // R2: STOP in the middle of a data byte stores nothing
    w0 = wr_pulses;
    bus_start();
    send_byte(devb(9'h060, 1'b0), ack); chk("R2 device ack", ack, 1);
    send_byte(8'h60, ack);              chk("R2 word address ack", ack, 1);
    send_bits(8'h00, 4);
    bus_stop();
    chk("R2 no strobe after mid-byte STOP", wr_pulses - w0, 0);
    do_read(9'h060, 1, 1'b1);

    summary();
    $finish;
  end
endmodule